// File: doc/BRIEF.md
# Control Transfer Prediction Decoder

This block sits in the front end beside instruction decode. When a control-transfer instruction is presented with a valid strobe, it works out what kind of transfer the instruction is. It then produces a predicted next PC and a two-bit prediction code that says how much to trust that PC. The block issues single-cycle requests to a return-address stack and to a direction predictor. Both of those units sit outside the block, and their responses come back combinationally in the same cycle as the request.

The code separates four cases. Direct jumps and calls carry code 2 (taken, no speculation), because both their direction and target are known at decode. Returns carry code 1 (taken speculatively) and take their target from the stack. Register-indirect jumps carry code 3 (unknown) with an all-ones target. Conditional branches carry code 1 or 0, taken from the predictor. The one exception is the branch-never form, which is always predicted taken so that it fetches ahead on purpose. All results are registered and appear one cycle after the request, behind their own valid strobe.

Top module: `ctp_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_code` is 0 (not taken).
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_code` and `out_target` keep their last values.
- R3: For `xfer_kind` = 2 (direct jump), `out_code` is 2 and `out_target` is `fetch_pc + imm*4`. No stack or predictor request is made.
- R4: For `xfer_kind` = 3 (direct call), `out_code` is 2 and `out_target` is `fetch_pc + imm*4`. In the accept cycle `ras_push` is high with `ras_push_addr` = `insn_pc + 8`.
- R5: For `xfer_kind` = 4 (return), `ras_pop` is high in the accept cycle. `out_code` is 1 and `out_target` equals the `ras_pop_addr` value sampled in that cycle.
- R6: For `xfer_kind` = 1, 5, 6 or 7 (register-indirect), `out_code` is 3 and `out_target` is all ones. No request is made.
- R7: For `xfer_kind` = 0 with `is_cond` = 1 and `cond_field` = 0 (branch-never), `out_code` is 1 and `out_target` is `insn_pc + imm*4`. No predictor lookup is made.
- R8: Every other `xfer_kind` = 0 case raises `dir_lookup` with `dir_lookup_pc` = `insn_pc` and `dir_lookup_hint` = `static_hint`. If `dir_taken` is 1, the result is code 1 and target `insn_pc + imm*4`. If it is 0, the result is code 0 and target `insn_pc + 8`.
- R9: `imm` is a signed word offset that is sign-extended before it is scaled by 4, and all address sums wrap modulo 2^32.
- R10: `ras_push` and `ras_pop` are never high in the same cycle. No request output is high while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A transfer instruction is presented this cycle |
| insn_pc | input | 32 | Address of the transfer instruction |
| fetch_pc | input | 32 | Current fetch PC, the base for direct jumps and calls |
| imm | input | 22 | Signed word displacement |
| xfer_kind | input | 3 | Unconditional kind: 0 conditional, 2 jump, 3 call, 4 return, others indirect |
| is_cond | input | 1 | Instruction is a conditional branch |
| cond_field | input | 4 | Branch condition; 0 means branch-never |
| static_hint | input | 1 | Compile-time direction hint passed to the predictor |
| ras_push | output | 1 | Push request to the return-address stack |
| ras_push_addr | output | 32 | Link address to push |
| ras_pop | output | 1 | Pop request to the return-address stack |
| ras_pop_addr | input | 32 | Top-of-stack address returned for a pop |
| dir_lookup | output | 1 | Direction lookup request |
| dir_lookup_pc | output | 32 | PC used to index the predictor |
| dir_lookup_hint | output | 1 | Static hint forwarded with the lookup |
| dir_taken | input | 1 | Predicted direction returned by the predictor |
| out_valid | output | 1 | Registered result is valid |
| out_code | output | 2 | 0 not taken, 1 speculative taken, 2 certain taken, 3 unknown |
| out_target | output | 32 | Predicted next PC |

## Verification
The branch-never case is the hardest to bring out from the ports. It differs from an ordinary conditional branch only in the condition field, and when the stub predictor happens to say taken, both cases give the same code and target. The stimulus therefore holds `dir_taken` at 0 while it presents the branch-never form. Any leak of the predictor answer would then show up as code 0 and a fall-through target, and the bench also checks that `dir_lookup` stays low in that cycle. Wrap and sign extension are reached with a negative displacement from a PC near zero and a positive displacement from a PC near the top of the address space.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

    typedef enum logic [1:0] {
        PC_NOT_TAKEN   = 2'd0,
        PC_SPEC_TAKEN  = 2'd1,
        PC_FIXED_TAKEN = 2'd2,
        PC_UNKNOWN     = 2'd3
    } pred_code_e;

    typedef enum logic [2:0] {
        RT_FETCH_REL,
        RT_INSN_REL,
        RT_FALLTHRU,
        RT_STACK,
        RT_ALL_ONES
    } route_e;

    localparam logic [2:0] KIND_JUMP   = 3'd2;
    localparam logic [2:0] KIND_CALL   = 3'd3;
    localparam logic [2:0] KIND_RETURN = 3'd4;

    typedef struct packed {
        pred_code_e code;
        route_e     route;
        logic       push;
        logic       pop;
        logic       lookup;
    } decision_t;

endpackage

// File: rtl/ctp_classify.sv
module ctp_classify
    import ctp_pkg::*;
#(
    parameter int KIND_W = 3,
    parameter int COND_W = 4
) (
    input  logic              in_valid,
    input  logic [KIND_W-1:0] xfer_kind,
    input  logic              is_cond,
    input  logic [COND_W-1:0] cond_field,
    input  logic              dir_taken,
    output decision_t         dec
);
    logic branch_never;
    assign branch_never = is_cond && (cond_field == '0);

    always_comb begin
        dec = '{code: PC_NOT_TAKEN, route: RT_FALLTHRU,
                push: 1'b0, pop: 1'b0, lookup: 1'b0};
        if (xfer_kind == KIND_W'(KIND_JUMP) || xfer_kind == KIND_W'(KIND_CALL)) begin
            dec.code  = PC_FIXED_TAKEN;
            dec.route = RT_FETCH_REL;
            dec.push  = in_valid && (xfer_kind == KIND_W'(KIND_CALL));
        end else if (xfer_kind == KIND_W'(KIND_RETURN)) begin
            dec.code  = PC_SPEC_TAKEN;
            dec.route = RT_STACK;
            dec.pop   = in_valid;
        end else if (xfer_kind != '0) begin
            dec.code  = PC_UNKNOWN;
            dec.route = RT_ALL_ONES;
        end else if (branch_never) begin
            dec.code  = PC_SPEC_TAKEN;
            dec.route = RT_INSN_REL;
        end else begin
            dec.lookup = in_valid;
            dec.code   = dir_taken ? PC_SPEC_TAKEN : PC_NOT_TAKEN;
            dec.route  = dir_taken ? RT_INSN_REL : RT_FALLTHRU;
        end
    end
endmodule

// File: rtl/ctp_target.sv
module ctp_target
    import ctp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 22,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] insn_pc,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [IMM_W-1:0]  imm,
    input  route_e            route,
    input  logic [ADDR_W-1:0] stack_addr,
    output logic [ADDR_W-1:0] link_addr,
    output logic [ADDR_W-1:0] target
);
    localparam int SHIFT   = $clog2(INSN_BYTES);
    localparam int EXT_W   = ADDR_W - IMM_W;
    localparam logic [ADDR_W-1:0] SKIP = ADDR_W'(2 * INSN_BYTES);

    logic [ADDR_W-1:0] disp;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp = {{EXT_W{imm[IMM_W-1]}}, imm} << SHIFT;
        end else begin : g_trunc
            assign disp = ADDR_W'(imm) << SHIFT;
        end
    endgenerate

    assign link_addr = insn_pc + SKIP;

    always_comb begin
        unique case (route)
            RT_FETCH_REL: target = fetch_pc + disp;
            RT_INSN_REL:  target = insn_pc + disp;
            RT_FALLTHRU:  target = link_addr;
            RT_STACK:     target = stack_addr;
            default:      target = '1;
        endcase
    end
endmodule

// File: rtl/ctp_decoder.sv
module ctp_decoder
    import ctp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 22,
    parameter int KIND_W     = 3,
    parameter int COND_W     = 4,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] insn_pc,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [KIND_W-1:0] xfer_kind,
    input  logic              is_cond,
    input  logic [COND_W-1:0] cond_field,
    input  logic              static_hint,
    output logic              ras_push,
    output logic [ADDR_W-1:0] ras_push_addr,
    output logic              ras_pop,
    input  logic [ADDR_W-1:0] ras_pop_addr,
    output logic              dir_lookup,
    output logic [ADDR_W-1:0] dir_lookup_pc,
    output logic              dir_lookup_hint,
    input  logic              dir_taken,
    output logic              out_valid,
    output logic [1:0]        out_code,
    output logic [ADDR_W-1:0] out_target
);
    decision_t         dec;
    logic [ADDR_W-1:0] tgt_d;
    logic [ADDR_W-1:0] link;

    ctp_classify #(.KIND_W(KIND_W), .COND_W(COND_W)) u_cls (
        .in_valid   (in_valid),
        .xfer_kind  (xfer_kind),
        .is_cond    (is_cond),
        .cond_field (cond_field),
        .dir_taken  (dir_taken),
        .dec        (dec)
    );

    ctp_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .insn_pc    (insn_pc),
        .fetch_pc   (fetch_pc),
        .imm        (imm),
        .route      (dec.route),
        .stack_addr (ras_pop_addr),
        .link_addr  (link),
        .target     (tgt_d)
    );

    assign ras_push        = dec.push;
    assign ras_push_addr   = link;
    assign ras_pop         = dec.pop;
    assign dir_lookup      = dec.lookup;
    assign dir_lookup_pc   = insn_pc;
    assign dir_lookup_hint = static_hint;

    pred_code_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            code_q     <= PC_NOT_TAKEN;
            out_target <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                code_q     <= dec.code;
                out_target <= tgt_d;
            end
        end
    end

    assign out_code = code_q;

    a_r10_one_stack_req: assert property (@(posedge clk) disable iff (rst)
        !(ras_push && ras_pop));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !(ras_push || ras_pop || dir_lookup));
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> ($stable(out_code) && $stable(out_target)));
    a_r4_push_on_call: assert property (@(posedge clk) disable iff (rst)
        ras_push |=> (out_code == 2'd2));
    a_r5_pop_result: assert property (@(posedge clk) disable iff (rst)
        ras_pop |=> (out_code == 2'd1 && out_target == $past(ras_pop_addr)));
    a_r6_unknown_all_ones: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_code == 2'd3) |-> (out_target == '1));
endmodule

// File: tb/tb_ctp_decoder.sv
module tb_ctp_decoder;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn_pc, fetch_pc;
    logic [21:0] imm;
    logic [2:0]  xfer_kind;
    logic        is_cond;
    logic [3:0]  cond_field;
    logic        static_hint;
    logic        ras_push, ras_pop, dir_lookup, dir_lookup_hint, dir_taken, out_valid;
    logic [31:0] ras_push_addr, ras_pop_addr, dir_lookup_pc, out_target;
    logic [1:0]  out_code;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_P/2) clk = ~clk;

    ctp_decoder dut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: act=%0d exp<=20000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic present(input logic [31:0] ipc, input logic [31:0] fpc, input logic [21:0] im,
                           input logic [2:0] k, input logic c, input logic [3:0] cf,
                           input logic h, input logic tk, input logic [31:0] stk);
        @(negedge clk);
        in_valid = 1; insn_pc = ipc; fetch_pc = fpc; imm = im; xfer_kind = k;
        is_cond = c; cond_field = cf; static_hint = h; dir_taken = tk; ras_pop_addr = stk;
        #1;
    endtask

    task automatic finish_cycle;
        @(negedge clk);
        in_valid = 0; dir_taken = 0; ras_pop_addr = 32'h0;
        #1;
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 64'd0);
        chk(out_code == 2'd0, "R1 code", 64'(out_code), 64'd0);
    endtask

    task automatic t_jump;
        present(32'h1000, 32'h1004, 22'd16, 3'd2, 0, 4'd0, 0, 0, 32'h0);
        chk(!ras_push && !ras_pop && !dir_lookup, "R3 no req", {ras_push, ras_pop, dir_lookup}, 64'd0);
        chk(!out_valid, "R2 not yet valid", 64'(out_valid), 64'd0);
        finish_cycle();
        chk(out_valid, "R2 valid", 64'(out_valid), 64'd1);
        chk(out_code == 2'd2, "R3 code", 64'(out_code), 64'd2);
        chk(out_target == 32'h1044, "R3 target", 64'(out_target), 64'h1044);
    endtask

    task automatic t_hold;
        @(negedge clk); #1;
        chk(!out_valid, "R2 valid drops", 64'(out_valid), 64'd0);
        chk(out_code == 2'd2 && out_target == 32'h1044, "R2 hold", {out_code, out_target}, {2'd2, 32'h1044});
        chk(!ras_push && !ras_pop && !dir_lookup, "R10 idle quiet", {ras_push, ras_pop, dir_lookup}, 64'd0);
    endtask

    task automatic t_call;
        present(32'h2000, 32'h2004, 22'd3, 3'd3, 0, 4'd1, 0, 0, 32'h0);
        chk(ras_push && !ras_pop, "R4 push", {ras_push, ras_pop}, 64'b10);
        chk(ras_push_addr == 32'h2008, "R4 link", 64'(ras_push_addr), 64'h2008);
        finish_cycle();
        chk(out_code == 2'd2, "R4 code", 64'(out_code), 64'd2);
        chk(out_target == 32'h2010, "R4 target", 64'(out_target), 64'h2010);
    endtask

    task automatic t_return;
        present(32'h3000, 32'h3004, 22'd5, 3'd4, 0, 4'd0, 0, 1, 32'hCAFE_0008);
        chk(ras_pop && !ras_push && !dir_lookup, "R5 pop", {ras_push, ras_pop, dir_lookup}, 64'b010);
        finish_cycle();
        chk(out_code == 2'd1, "R5 code", 64'(out_code), 64'd1);
        chk(out_target == 32'hCAFE_0008, "R5 target", 64'(out_target), 64'hCAFE0008);
    endtask

    task automatic t_indirect(input logic [2:0] k);
        present(32'h4000, 32'h4004, 22'd7, k, 1, 4'd3, 1, 1, 32'h1234);
        chk(!ras_push && !ras_pop && !dir_lookup, "R6 no req", {ras_push, ras_pop, dir_lookup}, 64'd0);
        finish_cycle();
        chk(out_code == 2'd3, "R6 code", 64'(out_code), 64'd3);
        chk(out_target == 32'hFFFF_FFFF, "R6 target", 64'(out_target), 64'hFFFFFFFF);
    endtask

    task automatic t_branch_never;
        present(32'h5000, 32'h5004, 22'd8, 3'd0, 1, 4'd0, 0, 0, 32'h0);
        chk(!dir_lookup, "R7 no lookup", 64'(dir_lookup), 64'd0);
        finish_cycle();
        chk(out_code == 2'd1, "R7 code", 64'(out_code), 64'd1);
        chk(out_target == 32'h5020, "R7 target", 64'(out_target), 64'h5020);
    endtask

    task automatic t_cond(input logic tk, input logic h);
        present(32'h6000, 32'h6004, 22'd4, 3'd0, 1, 4'd9, h, tk, 32'h0);
        chk(dir_lookup && dir_lookup_pc == 32'h6000 && dir_lookup_hint == h, "R8 lookup",
            {dir_lookup, dir_lookup_hint, dir_lookup_pc}, {1'b1, h, 32'h6000});
        finish_cycle();
        chk(out_code == (tk ? 2'd1 : 2'd0), "R8 code", 64'(out_code), tk ? 64'd1 : 64'd0);
        chk(out_target == (tk ? 32'h6010 : 32'h6008), "R8 target", 64'(out_target), tk ? 64'h6010 : 64'h6008);
    endtask

    task automatic t_wrap;
        present(32'h0000_0004, 32'h0000_0008, 22'h3F_FFFC, 3'd0, 1, 4'd0, 0, 0, 32'h0);
        finish_cycle();
        chk(out_target == 32'hFFFF_FFF4, "R9 negative wrap", 64'(out_target), 64'hFFFFFFF4);
        present(32'hFFFF_FFF0, 32'hFFFF_FFF8, 22'd4, 3'd2, 0, 4'd0, 0, 0, 32'h0);
        finish_cycle();
        chk(out_target == 32'h0000_0008, "R9 positive wrap", 64'(out_target), 64'h8);
        present(32'hFFFF_FFFC, 32'h0, 22'd0, 3'd0, 0, 4'd2, 0, 0, 32'h0);
        finish_cycle();
        chk(out_target == 32'h0000_0004, "R9 fallthrough wrap", 64'(out_target), 64'h4);
    endtask

    initial begin
        rst = 1; in_valid = 0; insn_pc = 0; fetch_pc = 0; imm = 0; xfer_kind = 0;
        is_cond = 0; cond_field = 0; static_hint = 0; dir_taken = 0; ras_pop_addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_jump();
        t_hold();
        t_call();
        t_return();
        t_indirect(3'd1);
        t_indirect(3'd5);
        t_indirect(3'd7);
        t_branch_never();
        t_cond(1'b1, 1'b0);
        t_cond(1'b0, 1'b1);
        t_wrap();
        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule